// File: doc/BRIEF.md
# Keyed Configuration Index/Data Window

This block is the configuration front end of a multi-function I/O controller. A host reaches it through two adjacent I/O addresses. The lower one is an index port, and the upper one is a data port. A strap input picks the base of that pair from two fixed values. Configuration space stays sealed until a key byte is written to the index port twice in a row. A separate exit key seals it again.

While the window is open, index writes load an index latch. Data-port accesses then act on the register that the latch names. A small set of global registers lives in the block itself: a logical-device selector, a two-byte device identifier, a revision byte and a two-byte vendor identifier. Indices at or above a local limit go to the selected logical device over a simple strobe-based register interface. Every read that hits the window returns its byte one clock after the strobe, together with a valid pulse.

Top module: `cfg_window_top`

## Requirements
- R1: After reset the window is sealed, the index latch and the device selector read 0x00, and no device-side strobe is active.
- R2: With `strap_alt` low the index port is address 0x2E and the data port 0x2F. With it high they are 0x4E and 0x4F. Accesses to any other address change no state and produce no read response.
- R3: The window opens only after two consecutive index-port writes of 0x87. A single 0x87 leaves it sealed.
- R4: An index-port write of any other byte between the two key writes restarts the unlock sequence.
- R5: While open, an index-port write of 0xAA seals the window and does not change the index latch.
- R6: While sealed, data-port writes are ignored, index-port writes other than keys do not change the latch, and every read of either port returns 0xFF.
- R7: While open, index 0x07 is the read/write device selector, and its value drives `ld_sel`.
- R8: While open, reads of indices 0x20/0x21 return the device identifier (default 0x0A51) high byte first. Index 0x22 returns the revision (default 0x03). Indices 0x23/0x24 return the vendor identifier 0x1934, high byte first.
- R9: While open, a data access to an index of 0x30 or above raises `ld_wr_en` or `ld_rd_en` for that strobe cycle, with `ld_reg_idx` equal to the index and `ld_wdata` equal to the host byte. The read returns `ld_rdata`. The two strobes are never both high.
- R10: While open, writes to global indices below 0x30 other than 0x07 are ignored, and reads of unassigned global indices return 0x00.
- R11: A read strobe that hits the window makes `io_rvalid` high in the next cycle, with the byte on `io_rdata`. An index-port read returns the latch while open. `io_rvalid` is high at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| strap_alt | input | 1 | Base select: 0 gives 0x2E/0x2F, 1 gives 0x4E/0x4F |
| io_strobe | input | 1 | One-cycle I/O access strobe |
| io_write | input | 1 | 1 = write, 0 = read, qualified by io_strobe |
| io_addr | input | ADDR_W | I/O address |
| io_wdata | input | 8 | Host write byte |
| io_rdata | output | 8 | Read byte, valid with io_rvalid |
| io_rvalid | output | 1 | Read response pulse, one cycle after the read strobe |
| ld_sel | output | 8 | Selected logical device number |
| ld_reg_idx | output | 8 | Device-local register index |
| ld_wr_en | output | 1 | Device-local write strobe |
| ld_rd_en | output | 1 | Device-local read strobe |
| ld_wdata | output | 8 | Device-local write byte |
| ld_rdata | input | 8 | Device-local read byte, sampled in the read strobe cycle |

## Verification
Several rules are checked by assertions on every cycle. The device-side strobes appear only while the window is open and only for local indices, and they are never both high. A sealed read always answers 0xFF, and an exit key always seals. The window opens only right after a key write, `io_rvalid` never appears without a preceding read, and the selector never moves while sealed. The bench scenarios are what show the ordering rules. These include the restart after a stray byte between keys and the exact identifier byte order. They also cover the strap choosing one address pair over the other, and the values held in the registers across a seal and a reopen.

// File: rtl/cfg_win_pkg.sv
`timescale 1ns/1ps
package cfg_win_pkg;
  localparam int BYTE_W = 8;

  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic [1:0] {
    LK_SEALED = 2'd0,
    LK_HALF   = 2'd1,
    LK_OPEN   = 2'd2
  } lock_state_t;

  typedef enum logic [1:0] {
    PORT_NONE  = 2'd0,
    PORT_INDEX = 2'd1,
    PORT_DATA  = 2'd2
  } port_hit_t;

  localparam byte_t IDX_LDSEL   = 8'h07;
  localparam byte_t IDX_DEV_HI  = 8'h20;
  localparam byte_t IDX_DEV_LO  = 8'h21;
  localparam byte_t IDX_REV     = 8'h22;
  localparam byte_t IDX_VEND_HI = 8'h23;
  localparam byte_t IDX_VEND_LO = 8'h24;
  localparam byte_t SEALED_READ = 8'hFF;
endpackage

// File: rtl/cfg_win_decode.sv
`timescale 1ns/1ps
module cfg_win_decode
  import cfg_win_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BASE_A = 16'h002E,
  parameter int BASE_B = 16'h004E
) (
  input  logic              strap_alt,
  input  logic [ADDR_W-1:0] io_addr,
  output port_hit_t         hit
);
  localparam int NUM_BASES = 2;

  logic [ADDR_W-1:0] base_tab [NUM_BASES];
  logic [ADDR_W-1:0] base_sel;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_BASES; gi++) begin : g_base
      localparam int BVAL = (gi == 0) ? BASE_A : BASE_B;
      assign base_tab[gi] = BVAL[ADDR_W-1:0];
    end
  endgenerate

  always_comb begin
    base_sel = base_tab[strap_alt];
    if (io_addr == base_sel)
      hit = PORT_INDEX;
    else if (io_addr == base_sel + ADDR_W'(1))
      hit = PORT_DATA;
    else
      hit = PORT_NONE;
  end
endmodule

// File: rtl/cfg_win_keyfsm.sv
`timescale 1ns/1ps
module cfg_win_keyfsm
  import cfg_win_pkg::*;
#(
  parameter logic [7:0] KEY_ENTER = 8'h87,
  parameter logic [7:0] KEY_EXIT  = 8'hAA
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  idx_wr,
  input  byte_t wdata,
  output logic  unlocked,
  output logic  idx_load
);
  lock_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      LK_SEALED: if (idx_wr && wdata == KEY_ENTER) state_d = LK_HALF;
      LK_HALF: begin
        if (idx_wr) state_d = (wdata == KEY_ENTER) ? LK_OPEN : LK_SEALED;
      end
      LK_OPEN: if (idx_wr && wdata == KEY_EXIT) state_d = LK_SEALED;
      default: state_d = LK_SEALED;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= LK_SEALED;
    else        state_q <= state_d;
  end

  assign unlocked = (state_q == LK_OPEN);
  assign idx_load = unlocked && idx_wr && (wdata != KEY_EXIT);
endmodule

// File: rtl/cfg_win_regs.sv
`timescale 1ns/1ps
module cfg_win_regs
  import cfg_win_pkg::*;
#(
  parameter logic [15:0] DEVICE_ID   = 16'h0A51,
  parameter logic [15:0] VENDOR_ID   = 16'h1934,
  parameter logic [7:0]  REVISION    = 8'h03,
  parameter logic [7:0]  LOCAL_LIMIT = 8'h30
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  unlocked,
  input  logic  idx_load,
  input  logic  idx_rd,
  input  logic  data_wr,
  input  logic  data_rd,
  input  byte_t wdata,
  input  byte_t ld_rdata,
  output byte_t index_q,
  output byte_t ldsel_q,
  output logic  ld_wr_en,
  output logic  ld_rd_en,
  output byte_t rdata_q,
  output logic  rvalid_q
);
  byte_t index_d, ldsel_d, rdata_d, global_rd;
  logic  rvalid_d, is_local, ldsel_we, index_ce, ldsel_ce, rdata_ce;

  assign is_local = (index_q >= LOCAL_LIMIT);
  assign ld_wr_en = unlocked && data_wr && is_local;
  assign ld_rd_en = unlocked && data_rd && is_local;
  assign ldsel_we = unlocked && data_wr && (index_q == IDX_LDSEL);

  always_comb begin
    case (index_q)
      IDX_LDSEL:   global_rd = ldsel_q;
      IDX_DEV_HI:  global_rd = DEVICE_ID[15:8];
      IDX_DEV_LO:  global_rd = DEVICE_ID[7:0];
      IDX_REV:     global_rd = REVISION;
      IDX_VEND_HI: global_rd = VENDOR_ID[15:8];
      IDX_VEND_LO: global_rd = VENDOR_ID[7:0];
      default:     global_rd = '0;
    endcase
  end

  always_comb begin
    index_ce = idx_load;
    index_d  = wdata;
    ldsel_ce = ldsel_we;
    ldsel_d  = wdata;
    rvalid_d = idx_rd || data_rd;
    rdata_ce = rvalid_d;
    if (!unlocked)     rdata_d = SEALED_READ;
    else if (idx_rd)   rdata_d = index_q;
    else if (is_local) rdata_d = ld_rdata;
    else               rdata_d = global_rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      index_q  <= '0;
      ldsel_q  <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      if (index_ce) index_q <= index_d;
      if (ldsel_ce) ldsel_q <= ldsel_d;
      if (rdata_ce) rdata_q <= rdata_d;
      rvalid_q <= rvalid_d;
    end
  end
endmodule

// File: rtl/cfg_window_top.sv
`timescale 1ns/1ps
module cfg_window_top
  import cfg_win_pkg::*;
#(
  parameter int          ADDR_W      = 16,
  parameter int          BASE_A      = 16'h002E,
  parameter int          BASE_B      = 16'h004E,
  parameter logic [7:0]  KEY_ENTER   = 8'h87,
  parameter logic [7:0]  KEY_EXIT    = 8'hAA,
  parameter logic [15:0] DEVICE_ID   = 16'h0A51,
  parameter logic [15:0] VENDOR_ID   = 16'h1934,
  parameter logic [7:0]  REVISION    = 8'h03,
  parameter logic [7:0]  LOCAL_LIMIT = 8'h30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_alt,
  input  logic              io_strobe,
  input  logic              io_write,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  output logic              io_rvalid,
  output logic [7:0]        ld_sel,
  output logic [7:0]        ld_reg_idx,
  output logic              ld_wr_en,
  output logic              ld_rd_en,
  output logic [7:0]        ld_wdata,
  input  logic [7:0]        ld_rdata
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  port_hit_t  hit;
  logic       idx_wr, idx_rd, data_wr, data_rd;
  logic       unlocked, idx_load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  cfg_win_decode #(
    .ADDR_W (ADDR_W),
    .BASE_A (BASE_A),
    .BASE_B (BASE_B)
  ) u_decode (
    .strap_alt (strap_alt),
    .io_addr   (io_addr),
    .hit       (hit)
  );

  assign idx_wr  = io_strobe &&  io_write && (hit == PORT_INDEX);
  assign idx_rd  = io_strobe && !io_write && (hit == PORT_INDEX);
  assign data_wr = io_strobe &&  io_write && (hit == PORT_DATA);
  assign data_rd = io_strobe && !io_write && (hit == PORT_DATA);

  cfg_win_keyfsm #(
    .KEY_ENTER (KEY_ENTER),
    .KEY_EXIT  (KEY_EXIT)
  ) u_keyfsm (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .idx_wr   (idx_wr),
    .wdata    (io_wdata),
    .unlocked (unlocked),
    .idx_load (idx_load)
  );

  cfg_win_regs #(
    .DEVICE_ID   (DEVICE_ID),
    .VENDOR_ID   (VENDOR_ID),
    .REVISION    (REVISION),
    .LOCAL_LIMIT (LOCAL_LIMIT)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .unlocked (unlocked),
    .idx_load (idx_load),
    .idx_rd   (idx_rd),
    .data_wr  (data_wr),
    .data_rd  (data_rd),
    .wdata    (io_wdata),
    .ld_rdata (ld_rdata),
    .index_q  (ld_reg_idx),
    .ldsel_q  (ld_sel),
    .ld_wr_en (ld_wr_en),
    .ld_rd_en (ld_rd_en),
    .rdata_q  (io_rdata),
    .rvalid_q (io_rvalid)
  );

  assign ld_wdata = io_wdata;
endmodule

// File: rtl/cfg_window_chk.sv
`timescale 1ns/1ps
module cfg_window_chk #(
  parameter int         ADDR_W      = 16,
  parameter int         BASE_A      = 16'h002E,
  parameter int         BASE_B      = 16'h004E,
  parameter logic [7:0] KEY_ENTER   = 8'h87,
  parameter logic [7:0] KEY_EXIT    = 8'hAA,
  parameter logic [7:0] LOCAL_LIMIT = 8'h30
) (
  input logic              clk,
  input logic              rst_n,
  input logic              strap_alt,
  input logic              io_strobe,
  input logic              io_write,
  input logic [ADDR_W-1:0] io_addr,
  input logic [7:0]        io_wdata,
  input logic [7:0]        io_rdata,
  input logic              io_rvalid,
  input logic [7:0]        ld_sel,
  input logic [7:0]        ld_reg_idx,
  input logic              ld_wr_en,
  input logic              ld_rd_en,
  input logic              unlocked
);
  logic [ADDR_W-1:0] base;
  logic win_hit, idx_key_wr, idx_exit_wr, any_rd;

  assign base        = strap_alt ? BASE_B[ADDR_W-1:0] : BASE_A[ADDR_W-1:0];
  assign win_hit     = (io_addr == base) || (io_addr == base + ADDR_W'(1));
  assign any_rd      = io_strobe && !io_write && win_hit;
  assign idx_key_wr  = io_strobe && io_write && (io_addr == base) && (io_wdata == KEY_ENTER);
  assign idx_exit_wr = io_strobe && io_write && (io_addr == base) && (io_wdata == KEY_EXIT);

  AST_LD_STROBE_NEEDS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_wr_en || ld_rd_en) |-> (unlocked && ld_reg_idx >= LOCAL_LIMIT)); // R9
  AST_LD_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_wr_en && ld_rd_en)); // R9
  AST_SEALED_READ_FF: assert property (@(posedge clk) disable iff (!rst_n)
    (any_rd && !unlocked) |=> (io_rvalid && io_rdata == 8'hFF)); // R6
  AST_EXIT_SEALS: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_exit_wr && unlocked) |=> !unlocked); // R5
  AST_OPEN_AFTER_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(idx_key_wr)); // R3
  AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    io_rvalid |-> $past(any_rd)); // R11
  AST_LDSEL_FROZEN_SEALED: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |=> $stable(ld_sel)); // R6
endmodule

bind cfg_window_top cfg_window_chk #(
  .ADDR_W      (ADDR_W),
  .BASE_A      (BASE_A),
  .BASE_B      (BASE_B),
  .KEY_ENTER   (KEY_ENTER),
  .KEY_EXIT    (KEY_EXIT),
  .LOCAL_LIMIT (LOCAL_LIMIT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .strap_alt  (strap_alt),
  .io_strobe  (io_strobe),
  .io_write   (io_write),
  .io_addr    (io_addr),
  .io_wdata   (io_wdata),
  .io_rdata   (io_rdata),
  .io_rvalid  (io_rvalid),
  .ld_sel     (ld_sel),
  .ld_reg_idx (ld_reg_idx),
  .ld_wr_en   (ld_wr_en),
  .ld_rd_en   (ld_rd_en),
  .unlocked   (unlocked)
);

// File: tb/cfg_window_top_tb.sv
`timescale 1ns/1ps
module cfg_window_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strap_alt = 1'b0;
  logic        io_strobe = 1'b0;
  logic        io_write = 1'b0;
  logic [15:0] io_addr = 16'h0000;
  logic [7:0]  io_wdata = 8'h00;
  logic [7:0]  io_rdata;
  logic        io_rvalid;
  logic [7:0]  ld_sel, ld_reg_idx, ld_wdata, ld_rdata;
  logic        ld_wr_en, ld_rd_en;

  int n_chk = 0;
  int n_bad = 0;
  int wr_count = 0;
  logic [7:0] last_wr_idx = 8'h00, last_wr_data = 8'h00;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  // device-side model: read byte is index xor 0x5A
  assign ld_rdata = ld_reg_idx ^ 8'h5A;

  always @(posedge clk) begin
    if (ld_wr_en) begin
      wr_count     <= wr_count + 1;
      last_wr_idx  <= ld_reg_idx;
      last_wr_data <= ld_wdata;
    end
  end

  cfg_window_top u_dut (
    .clk(clk), .rst_n(rst_n), .strap_alt(strap_alt),
    .io_strobe(io_strobe), .io_write(io_write), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .io_rvalid(io_rvalid),
    .ld_sel(ld_sel), .ld_reg_idx(ld_reg_idx), .ld_wr_en(ld_wr_en),
    .ld_rd_en(ld_rd_en), .ld_wdata(ld_wdata), .ld_rdata(ld_rdata)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); io_strobe = 1'b1; io_write = 1'b1; io_addr = a; io_wdata = d;
    @(negedge clk); io_strobe = 1'b0; io_write = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] v, output logic vl, output logic ldr);
    @(negedge clk); io_strobe = 1'b1; io_write = 1'b0; io_addr = a;
    #1 ldr = ld_rd_en;
    @(negedge clk); io_strobe = 1'b0; v = io_rdata; vl = io_rvalid;
  endtask

  // op: 0 index write, 1 data write, 2 index read, 3 data read ; {op, data, exp, req}
  localparam int NV = 23;
  localparam logic [21:0] VEC [NV] = '{
    {2'd0, 8'h87, 8'h00, 4'd3},  // R3 first key
    {2'd0, 8'h87, 8'h00, 4'd3},  // R3 second key
    {2'd0, 8'h20, 8'h00, 4'd8},
    {2'd3, 8'h00, 8'h0A, 4'd8},  // R8 device id high
    {2'd0, 8'h21, 8'h00, 4'd8},
    {2'd3, 8'h00, 8'h51, 4'd8},  // R8 device id low
    {2'd0, 8'h22, 8'h00, 4'd8},
    {2'd3, 8'h00, 8'h03, 4'd8},  // R8 revision
    {2'd0, 8'h23, 8'h00, 4'd8},
    {2'd3, 8'h00, 8'h19, 4'd8},  // R8 vendor high
    {2'd0, 8'h24, 8'h00, 4'd8},
    {2'd3, 8'h00, 8'h34, 4'd8},  // R8 vendor low
    {2'd0, 8'h07, 8'h00, 4'd7},
    {2'd1, 8'h06, 8'h00, 4'd7},  // R7 select device 6
    {2'd3, 8'h00, 8'h06, 4'd7},  // R7 read back
    {2'd2, 8'h00, 8'h07, 4'd11}, // R11 index read returns latch
    {2'd0, 8'h25, 8'h00, 4'd10},
    {2'd3, 8'h00, 8'h00, 4'd10}, // R10 unassigned global reads zero
    {2'd0, 8'h40, 8'h00, 4'd9},
    {2'd3, 8'h00, 8'h1A, 4'd9},  // R9 local read from device
    {2'd0, 8'hAA, 8'h00, 4'd5},  // R5 exit key
    {2'd3, 8'h00, 8'hFF, 4'd5},  // R5 sealed data read
    {2'd2, 8'h00, 8'hFF, 4'd6}   // R6 sealed index read
  };

  initial begin
    logic [7:0] v;
    logic vl, ldr;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 ld_sel", ld_sel, 8'h00);
    check("R1 ld_reg_idx", ld_reg_idx, 8'h00);
    check("R1 strobes", {6'd0, ld_wr_en, ld_rd_en}, 8'h00);
    rd(16'h002F, v, vl, ldr);
    check("R1 sealed read", v, 8'hFF);
    check("R11 rvalid on read", {7'd0, vl}, 8'h01);

    // table walk at base 0x2E
    for (int i = 0; i < NV; i++) begin
      logic [1:0] op;
      logic [7:0] d, e;
      string tag;
      op = VEC[i][21:20]; d = VEC[i][19:12]; e = VEC[i][11:4];
      tag = $sformatf("R%0d vec%0d", VEC[i][3:0], i);
      case (op)
        2'd0: wr(16'h002E, d);
        2'd1: wr(16'h002F, d);
        2'd2: begin rd(16'h002E, v, vl, ldr); check(tag, v, e); end
        default: begin rd(16'h002F, v, vl, ldr); check(tag, v, e); end
      endcase
    end

    // R4 stray byte between keys restarts
    wr(16'h002E, 8'h87); wr(16'h002E, 8'h11); wr(16'h002E, 8'h87);
    rd(16'h002F, v, vl, ldr);
    check("R4 still sealed", v, 8'hFF);
    // the pending single key plus one more opens
    wr(16'h002E, 8'h87);
    rd(16'h002E, v, vl, ldr);
    check("R4 open after two keys, latch kept", v, 8'h40);

    // R3 single key does not open
    wr(16'h002E, 8'hAA); wr(16'h002E, 8'h87);
    rd(16'h002F, v, vl, ldr);
    check("R3 single key sealed", v, 8'hFF);
    wr(16'h002E, 8'h00);

    // R6 sealed writes ignored
    wr(16'h002E, 8'h07); wr(16'h002F, 8'h33);
    check("R6 ld_sel unchanged", ld_sel, 8'h06);
    check("R6 no local write", wr_count[7:0], 8'h00);
    wr(16'h002E, 8'h87); wr(16'h002E, 8'h87);
    rd(16'h002E, v, vl, ldr);
    check("R6 latch unchanged while sealed", v, 8'h40);

    // R9 local write and read strobes
    wr(16'h002E, 8'h31); wr(16'h002F, 8'hC3);
    check("R9 local write count", wr_count[7:0], 8'h01);
    check("R9 local write idx", last_wr_idx, 8'h31);
    check("R9 local write data", last_wr_data, 8'hC3);
    rd(16'h002F, v, vl, ldr);
    check("R9 ld_rd_en during read", {7'd0, ldr}, 8'h01);
    check("R9 local read data", v, 8'h6B);

    // R10 read-only and unassigned globals ignore writes
    wr(16'h002E, 8'h21); wr(16'h002F, 8'h00);
    rd(16'h002F, v, vl, ldr);
    check("R10 id byte unchanged", v, 8'h51);
    check("R10 global read no ld_rd_en", {7'd0, ldr}, 8'h00);
    wr(16'h002E, 8'h2F); wr(16'h002F, 8'h55);
    check("R10 ld_sel unchanged", ld_sel, 8'h06);
    check("R10 no local write", wr_count[7:0], 8'h01);

    // R11 no rvalid after a write
    wr(16'h002E, 8'h22);
    check("R11 no rvalid after write", {7'd0, io_rvalid}, 8'h00);
    wr(16'h002E, 8'hAA);

    // R2 alternate base
    strap_alt = 1'b1;
    wr(16'h002E, 8'h87); wr(16'h002E, 8'h87);
    rd(16'h004F, v, vl, ldr);
    check("R2 old base ignored", v, 8'hFF);
    rd(16'h002F, v, vl, ldr);
    check("R2 no response off window", {7'd0, vl}, 8'h00);
    wr(16'h004E, 8'h87); wr(16'h004E, 8'h87);
    wr(16'h004E, 8'h22);
    rd(16'h004F, v, vl, ldr);
    check("R2 alt base revision", v, 8'h03);
    wr(16'h004E, 8'hAA);
    strap_alt = 1'b0;

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule